// File: doc/BRIEF.md
# DMA Controller Register and Interrupt File

This block is the software-visible register file of an eight-channel DMA controller. A simple 32-bit register bus (read strobe, write strobe, word address, write data, registered read data) reaches a small global area and one fixed-size window per channel. Each window holds the channel's control word, transfer size, 64-bit source address, 64-bit destination address and 64-bit link pointer. The control, size and address fields are exported to the transfer engines, together with a one-cycle start pulse per channel, a per-channel pending-abort request and a bitmap of enabled channels.

The transfer engines report back through three per-channel event strobes: done, error and aborted. Each event latches a flag in a combined status word, retires the channel (its enable and pending abort are cleared) and may raise the single interrupt line, depending on the per-event mask bits in that channel's control word. Software clears flags by writing ones to the status word.

Top module: `dmac_regfile`

## Requirements
- R1: After reset every channel register, the status word, the start pulses, the abort requests and the enable bitmap are zero, the interrupt line is low and the read data bus is zero.
- R2: Channel c owns the window at byte address 0x40 + 0x20*c; inside it the word offsets 0x00..0x1C hold control, size, source low, source high, destination low, destination high, link low, link high, and each reads back the last value written. Read data appears on the cycle after the read strobe and holds until the next read.
- R3: Address 0x10 reads the constant 0xC3404108 and ignores writes.
- R4: Control bit 0 is the channel enable; address 0x34 reads a bitmap whose bit c is channel c's enable. A control write with bit 0 set gives a start pulse on that channel for exactly the one cycle after the write; a write with bit 0 clear gives none.
- R5: Any write to address 0x20 clears the enable bit of every channel and every pending abort, leaving all other control bits unchanged.
- R6: A write to address 0x24 sets channel c's abort request only when write data bit c is 1 and channel c is enabled at that time; the request stays until the channel receives an event or a global channel reset.
- R7: An error event on channel c sets status bit c, an abort event sets bit 8+c and a done event sets bit 16+c; each event also clears the channel's enable bit on the same edge.
- R8: Writing address 0x30 clears exactly the status bits written as 1; an event arriving in the same cycle as a clear keeps its bit set.
- R9: The interrupt line is high whenever a status bit is set whose mask is 0: control bit 1 masks the done flag, bit 2 the error flag and bit 3 the abort flag of that channel. It follows the status word with no extra register stage.
- R10: Reads of any address not named above (including 0x20 and 0x24, and beyond the last channel window) return zero, and writes there change no state.
- R11: The control, size, source and destination registers of every channel are exported continuously to the engines, channel c at slice c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address (bits 1:0 ignored) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| evt_done | input | NCH | Per-channel transfer-complete event |
| evt_err | input | NCH | Per-channel error event |
| evt_abt | input | NCH | Per-channel aborted event |
| irq_o | output | 1 | Combined interrupt |
| start_o | output | NCH | One-cycle start pulse per channel |
| abort_req_o | output | NCH | Pending abort request per channel |
| chan_en_o | output | NCH | Enable bitmap |
| ch_ctrl_o | output | NCH*32 | Control words, channel c at [32c+:32] |
| ch_size_o | output | NCH*32 | Transfer sizes |
| ch_src_o | output | NCH*64 | Source addresses |
| ch_dst_o | output | NCH*64 | Destination addresses |

## Verification
Every register update lands on the clock edge that samples the strobe, so a write's effect on start_o, abort_req_o, chan_en_o and irq_o is visible one cycle after the write is presented, and an event's status flag and interrupt are visible one cycle after the event strobe. Read data is due one cycle after the read strobe. The bench drives every strobe on a falling edge for one cycle and samples on the following falling edge, which is exactly half a cycle after the rising edge that produced the result; the start pulse is also sampled one cycle later to prove it has dropped.

// File: rtl/dmac_rf_pkg.sv
package dmac_rf_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned WIN_REGS = 8;
  localparam int unsigned GRP_STEP = 8;
  localparam int unsigned ERR_LSB  = 0;
  localparam int unsigned ABT_LSB  = 8;
  localparam int unsigned TC_LSB   = 16;

  localparam int unsigned OFF_CFG   = 'h10;
  localparam int unsigned OFF_GCTL  = 'h20;
  localparam int unsigned OFF_ABT   = 'h24;
  localparam int unsigned OFF_ISTAT = 'h30;
  localparam int unsigned OFF_ENMAP = 'h34;
  localparam int unsigned OFF_WIN0  = 'h40;
  localparam int unsigned WIN_SHIFT = 5;

  localparam int unsigned CB_EN      = 0;
  localparam int unsigned CB_TC_MSK  = 1;
  localparam int unsigned CB_ERR_MSK = 2;
  localparam int unsigned CB_ABT_MSK = 3;

  typedef enum logic [2:0] {
    W_CTRL   = 3'd0,
    W_SIZE   = 3'd1,
    W_SRC_LO = 3'd2,
    W_SRC_HI = 3'd3,
    W_DST_LO = 3'd4,
    W_DST_HI = 3'd5,
    W_LNK_LO = 3'd6,
    W_LNK_HI = 3'd7
  } win_reg_e;
endpackage

// File: rtl/dmac_rf_chan.sv
module dmac_rf_chan
  import dmac_rf_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WIN_REGS-1:0] reg_we,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                evt_any,
  input  logic                glob_clr,
  input  logic                abt_we,
  input  logic                abt_bit,
  output logic [DATA_W-1:0]   ctrl_o,
  output logic [DATA_W-1:0]   size_o,
  output logic [2*DATA_W-1:0] src_o,
  output logic [2*DATA_W-1:0] dst_o,
  output logic [2*DATA_W-1:0] lnk_o,
  output logic                start_o,
  output logic                abt_pend_o
);
  logic [DATA_W-1:0] regs_q [WIN_REGS];
  logic start_q, abt_pend_q;
  logic ctrl_wr, retire, abt_accept;

  assign ctrl_wr    = reg_we[W_CTRL];
  assign retire     = evt_any | glob_clr;
  assign abt_accept = abt_we & abt_bit & regs_q[W_CTRL][CB_EN];

  for (genvar r = 0; r < WIN_REGS; r++) begin : g_reg
    if (r == int'(W_CTRL)) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          regs_q[r] <= '0;
        else if (reg_we[r])  regs_q[r] <= wdata;
        else if (retire)     regs_q[r][CB_EN] <= 1'b0;
      end
    end else begin : g_plain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          regs_q[r] <= '0;
        else if (reg_we[r])  regs_q[r] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q    <= 1'b0;
      abt_pend_q <= 1'b0;
    end else begin
      start_q <= ctrl_wr & wdata[CB_EN];
      if (retire)          abt_pend_q <= 1'b0;
      else if (abt_accept) abt_pend_q <= 1'b1;
    end
  end

  assign ctrl_o     = regs_q[W_CTRL];
  assign size_o     = regs_q[W_SIZE];
  assign src_o      = {regs_q[W_SRC_HI], regs_q[W_SRC_LO]};
  assign dst_o      = {regs_q[W_DST_HI], regs_q[W_DST_LO]};
  assign lnk_o      = {regs_q[W_LNK_HI], regs_q[W_LNK_LO]};
  assign start_o    = start_q;
  assign abt_pend_o = abt_pend_q;

  // R4: start lasts one cycle and coincides with an enabled channel
  p_start_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q || $past(ctrl_wr));
  p_start_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> regs_q[W_CTRL][CB_EN]);
  // R6: an abort request only appears for a channel enabled the cycle before
  p_abort_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abt_pend_q) |-> $past(regs_q[W_CTRL][CB_EN]));
  // R7/R5: retirement drops the enable unless software rewrites control
  p_retire_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !ctrl_wr) |=> !regs_q[W_CTRL][CB_EN] && !abt_pend_q);
endmodule

// File: rtl/dmac_rf_irq.sv
module dmac_rf_irq
  import dmac_rf_pkg::*;
#(
  parameter int unsigned NCH = 8
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    evt_err,
  input  logic [NCH-1:0]    evt_abt,
  input  logic [NCH-1:0]    evt_done,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_bits,
  input  logic [NCH-1:0]    msk_err,
  input  logic [NCH-1:0]    msk_abt,
  input  logic [NCH-1:0]    msk_tc,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  function automatic logic [DATA_W-1:0] place(input logic [NCH-1:0] e,
                                              input logic [NCH-1:0] a,
                                              input logic [NCH-1:0] t);
    logic [DATA_W-1:0] v;
    v = '0;
    v[ERR_LSB +: NCH] = e;
    v[ABT_LSB +: NCH] = a;
    v[TC_LSB  +: NCH] = t;
    return v;
  endfunction

  logic [DATA_W-1:0] status_q, set_vec, clr_vec, msk_vec;

  assign set_vec = place(evt_err, evt_abt, evt_done);
  assign msk_vec = place(msk_err, msk_abt, msk_tc);
  assign clr_vec = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr_vec) | set_vec;
  end

  assign status_o = status_q;
  assign irq_o    = |(status_q & ~msk_vec);

  // R7: every event leaves its flag set
  p_event_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));
  // R8: cleared bits are gone unless an event re-set them
  p_w1c_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((status_q & $past(clr_bits) & ~$past(set_vec)) == '0));
  // R8: bits not written as one and not evented are held
  p_w1c_keeps_r8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & ~$past(clr_vec)) == ($past(status_q) & ~$past(clr_vec)) | ($past(set_vec) & ~$past(clr_vec))));
endmodule

// File: rtl/dmac_regfile.sv
module dmac_regfile
  import dmac_rf_pkg::*;
#(
  parameter int unsigned NCH       = 8,
  parameter int unsigned ADDR_W    = 12,
  parameter logic [31:0] CFG_VALUE = 32'hC340_4108
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  rd_en,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  input  logic [NCH-1:0]        evt_done,
  input  logic [NCH-1:0]        evt_err,
  input  logic [NCH-1:0]        evt_abt,
  output logic                  irq_o,
  output logic [NCH-1:0]        start_o,
  output logic [NCH-1:0]        abort_req_o,
  output logic [NCH-1:0]        chan_en_o,
  output logic [NCH*DATA_W-1:0] ch_ctrl_o,
  output logic [NCH*DATA_W-1:0] ch_size_o,
  output logic [NCH*2*DATA_W-1:0] ch_src_o,
  output logic [NCH*2*DATA_W-1:0] ch_dst_o
);
  localparam int unsigned CH_W    = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int unsigned WIN_END = OFF_WIN0 + (NCH << WIN_SHIFT);

  function automatic logic [ADDR_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:2], 2'b00};
  endfunction
  function automatic logic win_hit(input logic [ADDR_W-1:0] a);
    return (a >= ADDR_W'(OFF_WIN0)) && (a < ADDR_W'(WIN_END));
  endfunction
  function automatic logic [CH_W-1:0] win_ch(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] rel;
    rel = a - ADDR_W'(OFF_WIN0);
    return rel[WIN_SHIFT +: CH_W];
  endfunction
  function automatic win_reg_e win_off(input logic [ADDR_W-1:0] a);
    return win_reg_e'(a[4:2]);
  endfunction

  logic [ADDR_W-1:0] waddr;
  logic              hit;
  logic [CH_W-1:0]   sel_ch;
  win_reg_e          sel_off;
  logic is_cfg, is_gctl, is_abt, is_istat, is_enmap, is_known;
  logic gctl_wr, abt_wr, istat_wr;

  assign waddr    = word_of(addr);
  assign hit      = win_hit(addr);
  assign sel_ch   = win_ch(addr);
  assign sel_off  = win_off(addr);
  assign is_cfg   = (waddr == ADDR_W'(OFF_CFG));
  assign is_gctl  = (waddr == ADDR_W'(OFF_GCTL));
  assign is_abt   = (waddr == ADDR_W'(OFF_ABT));
  assign is_istat = (waddr == ADDR_W'(OFF_ISTAT));
  assign is_enmap = (waddr == ADDR_W'(OFF_ENMAP));
  assign is_known = hit | is_cfg | is_istat | is_enmap;
  assign gctl_wr  = wr_en & is_gctl;
  assign abt_wr   = wr_en & is_abt;
  assign istat_wr = wr_en & is_istat;

  logic [DATA_W-1:0]   ctrl_a [NCH];
  logic [DATA_W-1:0]   size_a [NCH];
  logic [2*DATA_W-1:0] src_a  [NCH];
  logic [2*DATA_W-1:0] dst_a  [NCH];
  logic [2*DATA_W-1:0] lnk_a  [NCH];
  logic [NCH-1:0] evt_any, msk_err, msk_abt, msk_tc;
  logic [DATA_W-1:0] status;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic              ch_sel;
    logic [WIN_REGS-1:0] reg_we;
    assign ch_sel     = wr_en & hit & (sel_ch == CH_W'(c));
    assign reg_we     = ch_sel ? (WIN_REGS'(1) << sel_off) : '0;
    assign evt_any[c] = evt_done[c] | evt_err[c] | evt_abt[c];

    dmac_rf_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_we     (reg_we),
      .wdata      (wdata),
      .evt_any    (evt_any[c]),
      .glob_clr   (gctl_wr),
      .abt_we     (abt_wr),
      .abt_bit    (wdata[c]),
      .ctrl_o     (ctrl_a[c]),
      .size_o     (size_a[c]),
      .src_o      (src_a[c]),
      .dst_o      (dst_a[c]),
      .lnk_o      (lnk_a[c]),
      .start_o    (start_o[c]),
      .abt_pend_o (abort_req_o[c])
    );

    assign chan_en_o[c] = ctrl_a[c][CB_EN];
    assign msk_tc[c]    = ctrl_a[c][CB_TC_MSK];
    assign msk_err[c]   = ctrl_a[c][CB_ERR_MSK];
    assign msk_abt[c]   = ctrl_a[c][CB_ABT_MSK];
    assign ch_ctrl_o[c*DATA_W +: DATA_W]     = ctrl_a[c];
    assign ch_size_o[c*DATA_W +: DATA_W]     = size_a[c];
    assign ch_src_o[c*2*DATA_W +: 2*DATA_W]  = src_a[c];
    assign ch_dst_o[c*2*DATA_W +: 2*DATA_W]  = dst_a[c];
  end

  dmac_rf_irq #(.NCH(NCH)) u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_err  (evt_err),
    .evt_abt  (evt_abt),
    .evt_done (evt_done),
    .clr_we   (istat_wr),
    .clr_bits (wdata),
    .msk_err  (msk_err),
    .msk_abt  (msk_abt),
    .msk_tc   (msk_tc),
    .status_o (status),
    .irq_o    (irq_o)
  );

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (hit) begin
      unique case (sel_off)
        W_CTRL:   rd_mux = ctrl_a[sel_ch];
        W_SIZE:   rd_mux = size_a[sel_ch];
        W_SRC_LO: rd_mux = src_a[sel_ch][DATA_W-1:0];
        W_SRC_HI: rd_mux = src_a[sel_ch][2*DATA_W-1:DATA_W];
        W_DST_LO: rd_mux = dst_a[sel_ch][DATA_W-1:0];
        W_DST_HI: rd_mux = dst_a[sel_ch][2*DATA_W-1:DATA_W];
        W_LNK_LO: rd_mux = lnk_a[sel_ch][DATA_W-1:0];
        W_LNK_HI: rd_mux = lnk_a[sel_ch][2*DATA_W-1:DATA_W];
        default:  rd_mux = '0;
      endcase
    end else if (is_cfg) begin
      rd_mux = CFG_VALUE;
    end else if (is_istat) begin
      rd_mux = status;
    end else if (is_enmap) begin
      rd_mux = DATA_W'(chan_en_o);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R3: configuration reads return the constant
  p_cfg_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_cfg) |=> rdata == CFG_VALUE);
  // R10: undefined reads return zero
  p_undef_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !is_known) |=> rdata == '0);
  // R2: read data holds between reads
  p_rdata_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
  // R5: global channel reset leaves no channel enabled
  p_gctl_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    gctl_wr |=> chan_en_o == '0 && abort_req_o == '0);
endmodule

// File: tb/dmac_regfile_tb_top.sv
`timescale 1ns/1ps
module dmac_regfile_tb_top;
  localparam int NCH = 8;
  localparam int AW  = 12;
  localparam real CLK_P = 20.0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rd_en = 0, wr_en = 0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [NCH-1:0] evt_done = 0, evt_err = 0, evt_abt = 0;
  logic irq_o;
  logic [NCH-1:0] start_o, abort_req_o, chan_en_o;
  logic [NCH*32-1:0] ch_ctrl_o, ch_size_o;
  logic [NCH*64-1:0] ch_src_o, ch_dst_o;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_P/2) clk = ~clk;

  dmac_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .evt_done(evt_done), .evt_err(evt_err),
    .evt_abt(evt_abt), .irq_o(irq_o), .start_o(start_o),
    .abort_req_o(abort_req_o), .chan_en_o(chan_en_o), .ch_ctrl_o(ch_ctrl_o),
    .ch_size_o(ch_size_o), .ch_src_o(ch_src_o), .ch_dst_o(ch_dst_o));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic ev(input logic [NCH-1:0] e, input logic [NCH-1:0] a, input logic [NCH-1:0] t);
    @(negedge clk); evt_err = e; evt_abt = a; evt_done = t;
    @(negedge clk); evt_err = 0; evt_abt = 0; evt_done = 0;
  endtask

  function automatic logic [AW-1:0] wa(input int c, input int o);
    return AW'(32'h40 + 32'h20 * c + 4 * o);
  endfunction
  function automatic logic [31:0] pat(input int c, input int o);
    return {4'(c), 4'(o), 24'h5A3C00 + 24'(c * 16 + o * 2)};
  endfunction

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", irq_o, 0);
    chk("R1 start", start_o, 0);
    chk("R1 abort", abort_req_o, 0);
    chk("R1 enmap", chan_en_o, 0);
    chk("R1 rdata", rdata, 0);
    rd(wa(5, 1), v); chk("R1 size reg", v, 0);
    rd(12'h030, v);  chk("R1 status", v, 0);
    rd(12'h010, v);  chk("R3 cfg at reset", v, 32'hC3404108);
  endtask

  task automatic t_window();
    logic [31:0] v;
    int chs[3] = '{0, 3, 7};
    foreach (chs[k]) for (int o = 0; o < 8; o++) wr(wa(chs[k], o), pat(chs[k], o));
    foreach (chs[k]) for (int o = 0; o < 8; o++) begin
      rd(wa(chs[k], o), v); chk("R2 window readback", v, pat(chs[k], o));
    end
    chk("R11 src export ch3", ch_src_o[3*64 +: 64], {pat(3, 3), pat(3, 2)});
    chk("R11 dst export ch7", ch_dst_o[7*64 +: 64], {pat(7, 5), pat(7, 4)});
    chk("R11 size export ch0", ch_size_o[0 +: 32], pat(0, 1));
    chk("R11 ctrl export ch7", ch_ctrl_o[7*32 +: 32], pat(7, 0));
    rd(wa(1, 0), v); chk("R2 untouched channel", v, 0);
    chk("R2 rdata holds", rdata, 0);
  endtask

  task automatic t_cfg();
    logic [31:0] v;
    wr(12'h010, 32'h0);
    rd(12'h010, v); chk("R3 cfg ignores write", v, 32'hC3404108);
  endtask

  task automatic t_enable();
    logic [31:0] v;
    wr(wa(2, 0), 32'h0000_0001);
    chk("R4 start pulse", start_o, 8'h04);
    @(negedge clk);
    chk("R4 start drops", start_o, 8'h00);
    chk("R4 enable port", chan_en_o, 8'h04);
    rd(12'h034, v); chk("R4 enmap read", v, 32'h4);
    wr(wa(6, 0), 32'h0000_0F00);
    chk("R4 no start when bit0 clear", start_o, 8'h00);
  endtask

  task automatic t_abort();
    logic [31:0] v;
    wr(12'h024, 32'h0000_0024);
    chk("R6 abort only enabled", abort_req_o, 8'h04);
    ev(0, 8'h04, 0);
    chk("R6 abort cleared by event", abort_req_o, 8'h00);
    chk("R7 enable cleared by event", chan_en_o, 8'h00);
    rd(12'h030, v); chk("R7 abort flag bit 10", v, 32'h0000_0400);
    chk("R9 unmasked abort irq", irq_o, 1);
    wr(12'h030, 32'hFFFF_FFFF);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(wa(1, 0), 32'h0000_0003);
    ev(0, 0, 8'h02);
    rd(12'h030, v); chk("R7 done flag bit 17", v, 32'h0002_0000);
    chk("R9 masked done no irq", irq_o, 0);
    wr(wa(4, 0), 32'h0000_0009);
    ev(8'h10, 0, 0);
    chk("R9 unmasked error irq", irq_o, 1);
    chk("R7 enable drops on error", chan_en_o, 8'h00);
    wr(12'h030, 32'h0000_0010);
    chk("R9 irq falls after clear", irq_o, 0);
    rd(12'h030, v); chk("R8 clear only ones", v, 32'h0002_0000);
    wr(wa(1, 0), 32'h0000_0000);
    chk("R9 unmask raises irq", irq_o, 1);
    wr(12'h030, 32'hFFFF_FFFF);
    chk("R9 irq low after full clear", irq_o, 0);
  endtask

  task automatic t_race();
    logic [31:0] v;
    @(negedge clk); wr_en = 1; addr = 12'h030; wdata = 32'hFFFF_FFFF; evt_done = 8'h40;
    @(negedge clk); wr_en = 0; evt_done = 0;
    rd(12'h030, v); chk("R8 event beats clear", v, 32'h0040_0000);
    wr(12'h030, 32'hFFFF_FFFF);
  endtask

  task automatic t_gctl();
    logic [31:0] v;
    wr(wa(0, 0), 32'h00FF_3001);
    wr(wa(7, 0), 32'h0000_0001);
    wr(12'h024, 32'h0000_0080);
    chk("R6 abort ch7 accepted", abort_req_o, 8'h80);
    wr(12'h020, 32'h0);
    chk("R5 enables cleared", chan_en_o, 8'h00);
    chk("R5 aborts cleared", abort_req_o, 8'h00);
    rd(wa(0, 0), v); chk("R5 other ctrl bits kept", v, 32'h00FF_3000);
  endtask

  task automatic t_undef();
    logic [31:0] v, s0;
    wr(wa(3, 0), 32'h0000_0001);
    rd(wa(3, 1), s0);
    wr(12'h038, 32'hFFFF_FFFF);
    wr(12'h014, 32'hFFFF_FFFF);
    wr(AW'(32'h40 + 32'h20 * NCH), 32'hFFFF_FFFF);
    rd(12'h038, v); chk("R10 read 0x38", v, 0);
    rd(12'h000, v); chk("R10 read 0x00", v, 0);
    rd(12'h020, v); chk("R10 read 0x20", v, 0);
    rd(12'h024, v); chk("R10 read 0x24", v, 0);
    rd(AW'(32'h40 + 32'h20 * NCH), v); chk("R10 read past windows", v, 0);
    rd(wa(3, 1), v); chk("R10 size untouched", v, s0);
    chk("R10 enable untouched", chan_en_o, 8'h08);
    rd(12'h030, v); chk("R10 status untouched", v, 0);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_window();
    t_cfg();
    t_enable();
    t_abort();
    t_irq();
    t_race();
    t_gctl();
    t_undef();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule